// File: doc/BRIEF.md
# Overlapped Audio Frame Windower

This block sits between an audio sample source and a spectral stage. It takes signed 16-bit samples, one per strobe, and cuts them into frames of 320 samples. At a 16 kHz rate one frame covers 20 ms. Consecutive frames share half their samples, so a new frame falls due after every 160 fresh samples. Samples go into a 320-entry circular store, and each new sample replaces the oldest entry. Capture therefore never waits.

When a frame falls due, the block streams it out with the oldest sample first. On the way out, every sample is scaled by a Hamming window coefficient. The coefficients sit in a read-only table that is computed when the design is elaborated. The output is a valid/ready stream with markers on the first and the last beat. The data, the markers and the valid flag are held while ready is low.

The sample input has no back-pressure, and every strobe is taken. Frames are cut from the live store, so the consumer must keep up. If the next frame falls due before the previous one has been fully accepted, a sticky overrun flag is raised and the new frame is dropped.

Top module: `afw_frame_windower`

## Requirements
- R1: After reset, `out_valid` and `overrun` are 0 and no frame has been started.
- R2: No frame is emitted until 320 samples have been taken after reset. After only 319 samples, nothing appears.
- R3: A frame is exactly 320 accepted beats. `out_first` is 1 only on beat 0 and `out_last` is 1 only on beat 319.
- R4: Counting samples from 0 after reset, frame n carries samples n*160 through n*160+319 in arrival order. Beat k carries sample n*160+k.
- R5: The coefficient for beat k is unsigned Q1.15: round(32768*(0.54 - 0.46*cos(2*pi*k/319))).
- R6: Output beat k = (s*c + 16384) >> 15 (arithmetic shift), clipped to the range -32768..32767. Here s is the sample and c is its coefficient.
- R7: While `out_valid` is 1 and `out_ready` is 0, the output beat holds with unchanged data and markers.
- R8: `in_valid` is never refused. Samples that arrive while a frame is streaming out do not alter that frame, provided the consumer has accepted beat k before k new samples arrive.
- R9: If a frame falls due while the previous frame is not fully accepted, `overrun` becomes 1 and the new frame is never emitted. `overrun` stays 1 until reset.
- R10: Once the store is full, exactly one frame falls due per 160 samples. For N ≥ 320 samples, the frame count is 1 + (N-320)/160, rounded down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe; always accepted |
| in_data | input | 16 | Signed audio sample |
| out_valid | output | 1 | Windowed beat present |
| out_ready | input | 1 | Consumer accepts the beat |
| out_data | output | 16 | Signed windowed sample |
| out_first | output | 1 | Beat 0 of a frame |
| out_last | output | 1 | Beat 319 of a frame |
| overrun | output | 1 | Sticky: a frame was dropped |

## Verification
The assertions assume that `out_ready` may drop at any time. They do not assume that the consumer keeps pace. The beat-count and marker properties therefore hold even when frame data has been overwritten.

The stimulus spaces sample strobes three to six cycles apart. It pairs each ready pattern with a strobe gap that leaves the reader ahead of the writer, so that frame contents stay well defined.

One directed case holds ready low on purpose to force the overrun path. During that case, data comparison is switched off and only beat counts and flags are checked.

// File: rtl/afw_pkg.sv
package afw_pkg;
  localparam int SAMPLE_W = 16;
  localparam int COEF_W   = 16;

  // Hamming taper in unsigned Q1.15, evaluated at elaboration
  function automatic logic [COEF_W-1:0] hamming_q15(input int idx, input int len);
    real ph;
    real c;
    int  v;
    ph = 2.0 * 3.14159265358979 * real'(idx) / real'(len - 1);
    c  = 32768.0 * (0.54 - 0.46 * $cos(ph));
    v  = $rtoi(c + 0.5);
    return v[COEF_W-1:0];
  endfunction
endpackage

// File: rtl/afw_ring.sv
module afw_ring #(
  parameter int W     = 16,
  parameter int DEPTH = 320,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  // read sees the value before a same-cycle overwrite
  assign rdata = store[raddr];
endmodule

// File: rtl/afw_window_rom.sv
module afw_window_rom #(
  parameter int LEN  = 320,
  parameter int CW   = 16,
  localparam int AW  = $clog2(LEN)
) (
  input  logic [AW-1:0] addr,
  output logic [CW-1:0] coef
);
  logic [CW-1:0] tbl [LEN];

  for (genvar i = 0; i < LEN; i++) begin : g_tap
    assign tbl[i] = afw_pkg::hamming_q15(i, LEN);
  end

  assign coef = tbl[addr];
endmodule

// File: rtl/afw_scale.sv
module afw_scale #(
  parameter int SW = 16,
  parameter int CW = 16,
  localparam int PW = SW + CW + 1,
  localparam int FB = CW - 1
) (
  input  logic signed [SW-1:0] sample,
  input  logic        [CW-1:0] coef,
  output logic signed [SW-1:0] result
);
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FB - 1);
  localparam logic signed [PW-1:0] MAXV = PW'((1 << (SW - 1)) - 1);
  localparam logic signed [PW-1:0] MINV = -(PW'(1) <<< (SW - 1));

  logic signed [PW-1:0] prod, shifted;

  always_comb begin
    prod    = PW'(sample) * $signed({1'b0, coef});
    shifted = (prod + HALF) >>> FB;
    if (shifted > MAXV)      result = MAXV[SW-1:0];
    else if (shifted < MINV) result = MINV[SW-1:0];
    else                     result = shifted[SW-1:0];
  end
endmodule

// File: rtl/afw_sched.sv
module afw_sched #(
  parameter int LEN  = 320,
  parameter int HOP  = 160,
  localparam int AW  = $clog2(LEN),
  localparam int KW  = $clog2(LEN + 1),
  localparam int HW  = $clog2(HOP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          issue,
  input  logic          frame_done,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [KW-1:0] rd_k,
  output logic          pending,
  output logic          overrun
);
  logic [AW-1:0] wr_ptr, wr_ptr_nx, base;
  logic [AW-1:0] fill_cnt;
  logic [HW-1:0] hop_cnt;
  logic          primed, active, due;
  logic [AW:0]   sum;

  assign wr_ptr_nx = (wr_ptr == AW'(LEN - 1)) ? '0 : wr_ptr + 1'b1;
  assign due = in_valid && (primed ? (hop_cnt == HW'(HOP - 1))
                                   : (fill_cnt == AW'(LEN - 1)));
  assign wr_addr = wr_ptr;
  assign pending = active && (rd_k != KW'(LEN));

  always_comb begin
    sum = (AW + 1)'(base) + (AW + 1)'(rd_k);
    if (sum >= (AW + 1)'(LEN)) sum = sum - (AW + 1)'(LEN);
    rd_addr = sum[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      fill_cnt <= '0;
      hop_cnt  <= '0;
      primed   <= 1'b0;
      active   <= 1'b0;
      base     <= '0;
      rd_k     <= '0;
      overrun  <= 1'b0;
    end else begin
      if (in_valid) begin
        wr_ptr <= wr_ptr_nx;
        if (!primed) begin
          fill_cnt <= fill_cnt + 1'b1;
          if (fill_cnt == AW'(LEN - 1)) primed <= 1'b1;
        end else begin
          hop_cnt <= (hop_cnt == HW'(HOP - 1)) ? '0 : hop_cnt + 1'b1;
        end
      end
      if (issue)      rd_k   <= rd_k + 1'b1;
      if (frame_done) active <= 1'b0;
      if (due) begin
        if (active) begin
          overrun <= 1'b1;          // late frame dropped
        end else begin
          active <= 1'b1;
          base   <= wr_ptr_nx;      // oldest sample of the new frame
          rd_k   <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/afw_frame_windower.sv
module afw_frame_windower #(
  parameter int SW  = afw_pkg::SAMPLE_W,
  parameter int CW  = afw_pkg::COEF_W,
  parameter int LEN = 320,
  parameter int HOP = 160
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [SW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [SW-1:0] out_data,
  output logic          out_first,
  output logic          out_last,
  output logic          overrun
);
  localparam int AW = $clog2(LEN);
  localparam int KW = $clog2(LEN + 1);

  logic [AW-1:0] wr_addr, rd_addr, rom_addr;
  logic [KW-1:0] rd_k;
  logic          pending, issue, frame_done;
  logic [SW-1:0] raw;
  logic [CW-1:0] coef;
  logic signed [SW-1:0] scaled;

  assign issue      = pending && (!out_valid || out_ready);
  assign frame_done = out_valid && out_ready && out_last;
  assign rom_addr   = pending ? rd_k[AW-1:0] : '0;

  afw_sched #(.LEN(LEN), .HOP(HOP)) u_sched (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .issue(issue),
    .frame_done(frame_done), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .rd_k(rd_k), .pending(pending), .overrun(overrun)
  );

  afw_ring #(.W(SW), .DEPTH(LEN)) u_ring (
    .clk(clk), .we(in_valid), .waddr(wr_addr), .wdata(in_data),
    .raddr(rd_addr), .rdata(raw)
  );

  afw_window_rom #(.LEN(LEN), .CW(CW)) u_rom (
    .addr(rom_addr), .coef(coef)
  );

  afw_scale #(.SW(SW), .CW(CW)) u_scale (
    .sample($signed(raw)), .coef(coef), .result(scaled)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_first <= 1'b0;
      out_last  <= 1'b0;
    end else if (issue) begin
      out_valid <= 1'b1;
      out_data  <= scaled;
      out_first <= (rd_k == '0);
      out_last  <= (rd_k == KW'(LEN - 1));
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/afw_checker.sv
module afw_checker #(
  parameter int SW  = 16,
  parameter int LEN = 320
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          out_valid,
  input logic          out_ready,
  input logic [SW-1:0] out_data,
  input logic          out_first,
  input logic          out_last,
  input logic          overrun
);
  localparam int CNW = $clog2(LEN + 1);
  logic [CNW-1:0] seen, beat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= '0;
      beat <= '0;
    end else begin
      if (in_valid && seen != CNW'(LEN)) seen <= seen + 1'b1;
      if (out_valid && out_ready) beat <= out_last ? '0 : beat + 1'b1;
    end
  end

  a_r2_no_early_frame: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> seen == CNW'(LEN));

  a_r7_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)
                                && $stable(out_first) && $stable(out_last));

  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  a_r3_first_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_first |-> beat == '0);

  a_r3_last_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_last |-> beat == CNW'(LEN - 1));
endmodule

bind afw_frame_windower afw_checker #(.SW(SW), .LEN(LEN)) u_afw_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_first(out_first),
  .out_last(out_last), .overrun(overrun)
);

// File: tb/afw_frame_windower_bench.sv
module afw_frame_windower_bench;
  localparam int LEN = 320;
  localparam int HOP = 160;

  typedef struct packed {
    int kind;   // sample pattern
    int gap;    // cycles between strobes
    int rmode;  // 0 ready high, 1 alternating, 2 low one cycle in three
    int nsamp;
    int expf;   // expected frames (R10)
  } row_t;

  localparam row_t ROWS [5] = '{
    '{kind: 0, gap: 3, rmode: 0, nsamp: 320, expf: 1},
    '{kind: 1, gap: 6, rmode: 1, nsamp: 480, expf: 2},
    '{kind: 2, gap: 5, rmode: 2, nsamp: 640, expf: 3},
    '{kind: 0, gap: 5, rmode: 1, nsamp: 319, expf: 0},
    '{kind: 1, gap: 3, rmode: 0, nsamp: 799, expf: 3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic out_ready = 1'b0;
  logic out_valid, out_first, out_last, overrun;
  logic [15:0] out_data;

  int n_checks = 0;
  int n_fail = 0;
  int cur_kind = 0;
  int rmode = 0;
  bit chk_data = 1'b1;
  int frames = 0;
  int beats = 0;
  int k = 0;
  int mism = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  afw_frame_windower u_afw_frame_windower (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_first(out_first), .out_last(out_last), .overrun(overrun)
  );

  function automatic int sample_val(input int kind, input int i);
    case (kind)
      0:       return ((i * 1237 + 11) % 65536) - 32768;
      1:       return (i % 2) ? -32768 : 32767;
      default: return 16384 - (i % 7) * 3000;
    endcase
  endfunction

  // R5 coefficient
  function automatic int win_coef(input int n);
    real c;
    c = 32768.0 * (0.54 - 0.46 * $cos(2.0 * 3.14159265358979 * real'(n) / 319.0));
    return $rtoi(c + 0.5);
  endfunction

  // R6 rounding and clipping
  function automatic int expect_beat(input int kind, input int fr, input int kk);
    longint p, r;
    p = longint'(sample_val(kind, fr * HOP + kk)) * longint'(win_coef(kk));
    r = (p + 64'sd16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ready driver and output monitor
  initial begin
    int e, fe, fa;
    forever begin
      @(negedge clk);
      cyc++;
      case (rmode)
        0: out_ready = 1'b1;
        1: out_ready = (cyc % 2) == 0;
        2: out_ready = (cyc % 3) != 0;
        default: out_ready = 1'b0;
      endcase
      if (rst_n && out_valid && out_ready) begin
        beats++;
        if (chk_data) begin
          e = expect_beat(cur_kind, frames, k);
          if ($signed(out_data) != e || out_first != (k == 0) || out_last != (k == LEN - 1)) begin
            if (mism == 0) begin fa = int'($signed(out_data)); fe = e; end
            mism++;
          end
        end
        k++;
        if (out_last) begin
          // R3 R4 R5 R6 R8: every beat, marker and length of the frame
          if (chk_data)
            check(mism == 0 && k == LEN, "R3/R4/R5/R6/R8 frame content",
                  (mism == 0) ? k : fa, (mism == 0) ? LEN : fe);
          frames++;
          k = 0;
          mism = 0;
        end
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    frames = 0; beats = 0; k = 0; mism = 0;
    rst_n = 1'b1;
  endtask

  task automatic feed(input int kind, input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 16'(sample_val(kind, i));
      @(negedge clk);
      in_valid = 1'b0;
      repeat (gap - 2) @(negedge clk);
    end
  endtask

  initial begin
    rmode = 0;
    do_reset();
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(overrun == 1'b0, "R1 overrun after reset", overrun, 0);

    for (int r = 0; r < 5; r++) begin
      rmode = 0;
      chk_data = 1'b1;
      do_reset();
      cur_kind = ROWS[r].kind;
      rmode = ROWS[r].rmode;
      feed(ROWS[r].kind, ROWS[r].nsamp, ROWS[r].gap);
      repeat (1200) @(negedge clk);
      // R2 R10: frame count for the number of samples fed
      check(frames == ROWS[r].expf, "R2/R10 frame count", frames, ROWS[r].expf);
      check(overrun == 1'b0, "R9 no overrun when consumer keeps pace", overrun, 0);
    end

    // R9 forced overrun with R7 hold
    rmode = 0;
    do_reset();
    chk_data = 1'b0;
    rmode = 3;
    feed(0, 480, 3);
    repeat (2) @(negedge clk);
    check(overrun == 1'b1, "R9 overrun raised", overrun, 1);
    check(out_valid == 1'b1 && out_first == 1'b1, "R7 beat held under back-pressure",
          out_valid & out_first, 1);
    rmode = 0;
    repeat (800) @(negedge clk);
    check(frames == 1, "R9 late frame dropped", frames, 1);
    check(beats == LEN, "R9 only one frame of beats", beats, LEN);
    check(overrun == 1'b1, "R9 overrun sticky", overrun, 1);

    do_reset();
    chk_data = 1'b1;
    @(negedge clk);
    check(overrun == 1'b0, "R1 reset clears overrun", overrun, 0);
    check(out_valid == 1'b0, "R1 no output after reset", out_valid, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule